// File: doc/BRIEF.md
# Segmented Pulsed-Latch Shift Register

This block is a 256-bit serial shift register organised as 64 identical 4-bit segments. Each segment keeps four data elements and one temporary holding element. A single shift is not done on one common clock edge. It is split into five separate enable pulses, and at most one of them is active in any cycle. The holding element of every segment first takes a copy of that segment's last bit. The four data elements then load from their predecessors, from the far end back to the front. Each element is therefore read before it is overwritten. The first data element of a segment loads from the holding element of the segment before it. The first segment loads from the serial input.

A small sequencer runs on the fast system clock. It turns one request into the five-pulse train and drives each pulse line to the matching element of every segment at once. The user raises `shiftReq`, watches `busy`, and reads `done`, the serial output and the full parallel snapshot once the shift has completed.

Top module: `segmented_latch_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all data and holding elements and returns the sequencer to idle. After it, `snapshot` is all zeros, `serialOut` is 0 and `busy` and `done` are 0.
- R2: A request seen while idle raises `busy` at the next edge. `busy` stays high for exactly five cycles. `done` is high for the one cycle that follows.
- R3: No two pulse lines are ever high in the same cycle. A shift applies the holding pulse first, then the data pulses for element positions 3, 2, 1 and 0 within each segment, in that order.
- R4: After each completed shift, `snapshot` equals the previous snapshot moved up one position (bit i takes the old bit i-1) with bit 0 taken from `serialIn`. Bit 0 is the newest bit and bit 255 the oldest. Segment s holds bits 4s to 4s+3. `serialIn` is sampled in the last pulse cycle.
- R5: A bit at the top position 4s+3 of a segment reaches position 4s+4 of the next segment in one shift, through that segment's holding element.
- R6: A request that arrives while `busy` is high has no effect. Exactly one shift results, and `busy` is low in the cycle after `done`.
- R7: `serialOut` always equals snapshot bit 255. After 256 completed shifts it shows the first bit that was entered.
- R8: With no request, no element changes, whatever `serialIn` does.
- R9: `done` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data entering the first element |
| shiftReq | input | 1 | Request for one shift; ignored while busy |
| busy | output | 1 | Shift sequence in progress |
| done | output | 1 | One-cycle strobe after the last pulse |
| serialOut | output | 1 | Last data element of the last segment |
| snapshot | output | 256 | Parallel view of all data elements, bit 0 newest |

## Verification
A wrong pulse order or an overlap between pulses corrupts data in a way that shows at the ports. Either one bit is copied into two neighbouring positions, or a bit skips a position at a segment boundary. The full snapshot differs from the reference at the `done` cycle of that same shift. A sequencer that counts wrong shows up at once in the length of `busy` or in the placement of `done`. A request that is wrongly accepted while busy shows up as a second busy period, or as a snapshot that has moved two places. A broken serial path reaches `serialOut` only after 256 shifts, so the bench runs past that depth.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int SEG_BITS = 4;
  localparam int PHASES   = SEG_BITS + 1;

  typedef struct packed {
    logic                tmpPulse;
    logic [SEG_BITS-1:0] dataPulse;
  } pulse_t;
endpackage

// File: rtl/pls_sequencer.sv
module pls_sequencer
  import pls_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shiftReq,
  output pulse_t pulses,
  output logic   busy,
  output logic   done
);
  localparam int PW = $clog2(PHASES);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic          active;
  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (shiftReq) begin
          active <= 1'b1;
          phase  <= '0;
        end
      end else if (phase == LAST) begin
        active <= 1'b0;
        phase  <= '0;
        done   <= 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    pulses = '0;
    if (active) begin
      pulses.tmpPulse = (phase == '0);
      for (int k = 0; k < SEG_BITS; k++) begin
        if (phase == PW'(SEG_BITS - k)) pulses.dataPulse[k] = 1'b1;
      end
    end
  end

  assign busy = active;

  a_r3_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pulses.tmpPulse, pulses.dataPulse}));
  a_r3_order: assert property (@(posedge clk) disable iff (rst)
    pulses.tmpPulse |=> pulses.dataPulse[SEG_BITS-1]);
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && shiftReq) |=> (busy && pulses.tmpPulse));
  a_r2_done_after_last: assert property (@(posedge clk) disable iff (rst)
    pulses.dataPulse[0] |=> (done && !busy));
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !pulses.dataPulse[0]) |=> busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pls_segment.sv
module pls_segment
  import pls_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  pulse_t              pulses,
  input  logic                segIn,
  output logic [SEG_BITS-1:0] dataQ,
  output logic                tmpQ
);
  always_ff @(posedge clk) begin
    if (rst)                  tmpQ <= 1'b0;
    else if (pulses.tmpPulse) tmpQ <= dataQ[SEG_BITS-1];
  end

  for (genvar k = 0; k < SEG_BITS; k++) begin : g_elem
    logic srcBit;
    if (k == 0) begin : g_first
      assign srcBit = segIn;
    end else begin : g_inner
      assign srcBit = dataQ[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst)                       dataQ[k] <= 1'b0;
      else if (pulses.dataPulse[k]) dataQ[k] <= srcBit;
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !pulses.dataPulse[k] |=> $stable(dataQ[k]));
  end
endmodule

// File: rtl/pls_datapath.sv
module pls_datapath
  import pls_pkg::*;
#(
  parameter int NUM_SEGS = 64,
  localparam int DEPTH = NUM_SEGS * SEG_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  pulse_t           pulses,
  input  logic             serialIn,
  output logic [DEPTH-1:0] snapshot,
  output logic             serialOut
);
  logic [NUM_SEGS-1:0] tmpChain;

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    logic segIn;
    if (s == 0) begin : g_head
      assign segIn = serialIn;
    end else begin : g_link
      assign segIn = tmpChain[s-1];
    end

    pls_segment u_seg (
      .clk   (clk),
      .rst   (rst),
      .pulses(pulses),
      .segIn (segIn),
      .dataQ (snapshot[s*SEG_BITS +: SEG_BITS]),
      .tmpQ  (tmpChain[s])
    );
  end

  assign serialOut = snapshot[DEPTH-1];

  a_r7_out_stable: assert property (@(posedge clk) disable iff (rst)
    !pulses.dataPulse[SEG_BITS-1] |=> $stable(serialOut));
  a_r5_tail_copy: assert property (@(posedge clk) disable iff (rst)
    pulses.tmpPulse |=> (tmpChain[NUM_SEGS-1] == serialOut));
endmodule

// File: rtl/segmented_latch_shifter.sv
module segmented_latch_shifter
  import pls_pkg::*;
#(
  parameter int NUM_SEGS = 64,
  localparam int DEPTH = NUM_SEGS * SEG_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serialIn,
  input  logic             shiftReq,
  output logic             busy,
  output logic             done,
  output logic             serialOut,
  output logic [DEPTH-1:0] snapshot
);
  pulse_t pulses;

  pls_sequencer u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .shiftReq(shiftReq),
    .pulses  (pulses),
    .busy    (busy),
    .done    (done)
  );

  pls_datapath #(.NUM_SEGS(NUM_SEGS)) u_data (
    .clk      (clk),
    .rst      (rst),
    .pulses   (pulses),
    .serialIn (serialIn),
    .snapshot (snapshot),
    .serialOut(serialOut)
  );
endmodule

// File: tb/segmented_latch_shifter_test.sv
module segmented_latch_shifter_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic shiftReq = 1'b0;
  logic busy, done, serialOut;
  logic [DEPTH-1:0] snapshot;
  logic [DEPTH-1:0] expected = '0;
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segmented_latch_shifter uut (
    .clk(clk), .rst(rst), .serialIn(serialIn), .shiftReq(shiftReq),
    .busy(busy), .done(done), .serialOut(serialOut), .snapshot(snapshot)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [DEPTH-1:0] act, input logic [DEPTH-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doShift(input logic b, input bit poke);
    logic [DEPTH-1:0] prev;
    prev = expected;
    serialIn = b;
    shiftReq = 1'b1;
    @(negedge clk);
    shiftReq = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      check(busy === 1'b1 && done === 1'b0, "R2 busy window", DEPTH'(busy), 1);
      if (poke && i == 2) shiftReq = 1'b1;
      if (poke && i == 3) shiftReq = 1'b0;
      @(negedge clk);
    end
    expected = {prev[DEPTH-2:0], b};
    check(busy === 1'b0 && done === 1'b1, "R2 done strobe", DEPTH'({busy, done}), 1);
    check(snapshot === expected, poke ? "R6 single shift" : "R4 snapshot", snapshot, expected);
    check(snapshot[4] === prev[3], "R5 boundary", DEPTH'(snapshot[4]), DEPTH'(prev[3]));
    check(serialOut === expected[DEPTH-1], "R7 serialOut", DEPTH'(serialOut),
          DEPTH'(expected[DEPTH-1]));
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", DEPTH'(done), 0);
    check(busy === 1'b0, "R6 no extra shift", DEPTH'(busy), 0);
  endtask

  initial begin
    logic firstBit;
    logic [DEPTH-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(snapshot === '0 && serialOut === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1 reset state", snapshot, '0);
    firstBit = 1'b1;
    for (int i = 0; i < 270; i++) begin
      logic b;
      b = (i == 0) ? firstBit : logic'(((i % 3) == 0) ^ ((i >> 4) & 1) ^ ((i * 5 >> 2) & 1));
      doShift(b, (i % 17) == 5);
      if (i == 255)
        check(serialOut === firstBit, "R7 first bit at depth", DEPTH'(serialOut),
              DEPTH'(firstBit));
    end
    held = snapshot;
    for (int i = 0; i < 12; i++) begin
      serialIn = ~serialIn;
      @(negedge clk);
    end
    check(snapshot === held && busy === 1'b0, "R8 idle hold", snapshot, held);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expected = '0;
    check(snapshot === '0 && serialOut === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1 reset after data", snapshot, '0);
    doShift(1'b1, 1'b0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule